// File: doc/BRIEF.md
# Oversampled I2S Audio Receiver

This block takes the three wires of a serial audio link (bit clock, word select and data) from a source that generates its own clocks. It recovers the audio words using only a faster, free-running system clock. The bit clock is never used as a clock. All three lines pass through synchronizers and are treated as data, and their edges are found by comparing each synchronized level with its level one system cycle earlier.

A start pulse arms the receiver. It then waits for word select to fall, which marks the beginning of a left-channel slot. From there it shifts in data bits on bit-clock rising edges, most significant first. It counts them against a runtime bit count and emits each finished word, tagged with its channel, on a valid/ready stream.

The usual setting for 24-bit samples that arrive one bit clock after the word-select transition is a count of 25. The output word keeps only its low `OUT_W` bits, so the leading pad bit is discarded. If a finished word finds the output still occupied, that word is dropped and a sticky flag is raised. A stop pulse returns the receiver to its waiting state.

Top module: `i2s_oversampled_rx`

## Requirements
- R1: While `rst` is high and on the cycle after it, `m_valid_o` and `overflow_o` are 0, and the receiver is in its waiting state.
- R2: After reset or stop, no word is emitted, however the serial lines toggle, until `start_i` has been pulsed.
- R3: Once armed, the receiver ignores all traffic until word select falls from 1 to 0. The first word it emits is therefore a left-channel word (`m_right_o` = 0).
- R4: Each rising edge of the synchronized bit clock causes exactly one data bit to be captured. That bit is the synchronized data level one system cycle after the edge was seen.
- R5: When the number of bits captured in a channel equals `bit_count_i` (1 to 32), a word is produced. Its value is those bits with the first received bit most significant. `m_data_o` carries the low `OUT_W` (24) bits of that value.
- R6: Any change of word select while reading discards the partial word and clears the bit counter. The new channel's tag is the new word-select level: 0 means left, 1 means right.
- R7: Bits that arrive after the count has been reached, and before the next word-select change, do not alter the emitted word and produce no further word.
- R8: While `m_valid_o` is 1 and `m_ready_i` is 0, the output holds `m_valid_o`, `m_data_o` and `m_right_o` unchanged.
- R9: A word that completes while a held word is still waiting is dropped, and `overflow_o` becomes 1. It stays 1 until stop or reset, and the held word is unaffected.
- R10: A `stop_i` pulse clears `m_valid_o` and `overflow_o` on the next cycle and returns the receiver to waiting for `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Arms capture when the receiver is waiting |
| stop_i | input | 1 | Returns to waiting and clears output and overflow |
| sck_i | input | 1 | Serial bit clock, sampled as data |
| ws_i | input | 1 | Word select, 0 = left, 1 = right |
| sd_i | input | 1 | Serial data |
| bit_count_i | input | 6 | Bits per channel to capture (1 to 32) |
| m_data_o | output | 24 | Captured word, low OUT_W bits |
| m_right_o | output | 1 | Channel tag of the word, 1 = right |
| m_valid_o | output | 1 | Word available |
| m_ready_i | input | 1 | Consumer accepts the word |
| overflow_o | output | 1 | Sticky: a word was dropped |

## Verification
The main path is driven with full 32-slot stereo frames that carry a one-bit delayed 24-bit payload at a count of 25. This shows whether the pad bit is masked off and whether the channels alternate correctly. A count of 16 with non-zero trailing bits separates most-significant-first assembly from capture that keeps going after the count is reached. A count of 32 shows the truncation to the low 24 bits. Arming in the middle of a right slot, and cutting a left slot short, show whether alignment waits for the word-select fall and whether an early word-select change discards the partial word. Stalling the consumer across two words separates holding the first word from overwriting it. Traffic sent before start and after stop shows whether the receiver stays quiet when it is not armed.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;
  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_SYNC = 2'd1,
    ST_READ = 2'd2
  } rx_state_e;
endpackage

// File: rtl/i2s_rx_sync.sv
module i2s_rx_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] chain [STAGES];
  logic [W-1:0] prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= '0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= chain[STAGES-1];
  end

  assign q_o    = chain[STAGES-1];
  assign rise_o = chain[STAGES-1] & ~prev_q;
  assign fall_o = ~chain[STAGES-1] & prev_q;
endmodule

// File: rtl/i2s_rx_ctrl.sv
module i2s_rx_ctrl
  import i2s_rx_pkg::*;
#(
  parameter int MAX_BITS = 32,
  parameter int CNT_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic                sck_rise_i,
  input  logic                ws_lvl_i,
  input  logic                ws_rise_i,
  input  logic                ws_fall_i,
  input  logic                sd_lvl_i,
  input  logic [CNT_W-1:0]    bit_count_i,
  output logic                done_o,
  output logic [MAX_BITS-1:0] word_o,
  output logic                word_right_o,
  output rx_state_e           state_o
);
  rx_state_e           state;
  logic [CNT_W-1:0]    cnt;
  logic [MAX_BITS-1:0] shreg;
  logic                chan;
  logic                pending;
  logic [CNT_W-1:0]    cnt_nxt;
  logic [MAX_BITS-1:0] shreg_nxt;

  assign cnt_nxt   = cnt + CNT_W'(1);
  assign shreg_nxt = {shreg[MAX_BITS-2:0], sd_lvl_i};

  always_ff @(posedge clk) begin
    if (rst || stop_i) begin
      state        <= ST_WAIT;
      cnt          <= '0;
      shreg        <= '0;
      chan         <= 1'b0;
      pending      <= 1'b0;
      done_o       <= 1'b0;
      word_o       <= '0;
      word_right_o <= 1'b0;
    end else begin
      done_o  <= 1'b0;
      pending <= sck_rise_i;
      unique case (state)
        ST_WAIT: if (start_i) state <= ST_SYNC;
        ST_SYNC: begin
          if (ws_fall_i) begin
            state <= ST_READ;
            cnt   <= '0;
            shreg <= '0;
            chan  <= 1'b0;
          end
        end
        ST_READ: begin
          if (ws_rise_i || ws_fall_i) begin
            cnt   <= '0;
            shreg <= '0;
            chan  <= ws_lvl_i;
          end else if (pending && (cnt < bit_count_i)) begin
            shreg <= shreg_nxt;
            cnt   <= cnt_nxt;
            if (cnt_nxt == bit_count_i) begin
              done_o       <= 1'b1;
              word_o       <= shreg_nxt;
              word_right_o <= chan;
            end
          end
        end
        default: state <= ST_WAIT;
      endcase
    end
  end

  assign state_o = state;
endmodule

// File: rtl/i2s_rx_outreg.sv
module i2s_rx_outreg #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stop_i,
  input  logic             done_i,
  input  logic [IN_W-1:0]  word_i,
  input  logic             right_i,
  output logic [OUT_W-1:0] data_o,
  output logic             right_o,
  output logic             valid_o,
  input  logic             ready_i,
  output logic             overflow_o
);
  always_ff @(posedge clk) begin
    if (rst || stop_i) begin
      valid_o    <= 1'b0;
      overflow_o <= 1'b0;
      data_o     <= '0;
      right_o    <= 1'b0;
    end else if (done_i) begin
      if (!valid_o || ready_i) begin
        valid_o <= 1'b1;
        data_o  <= word_i[OUT_W-1:0];
        right_o <= right_i;
      end else begin
        overflow_o <= 1'b1;
      end
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/i2s_oversampled_rx.sv
module i2s_oversampled_rx
  import i2s_rx_pkg::*;
#(
  parameter int MAX_BITS    = 32,
  parameter int OUT_W       = 24,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(MAX_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             sck_i,
  input  logic             ws_i,
  input  logic             sd_i,
  input  logic [CNT_W-1:0] bit_count_i,
  output logic [OUT_W-1:0] m_data_o,
  output logic             m_right_o,
  output logic             m_valid_o,
  input  logic             m_ready_i,
  output logic             overflow_o
);
  localparam int LINES = 3;
  localparam int L_SCK = 0;
  localparam int L_WS  = 1;
  localparam int L_SD  = 2;

  logic [LINES-1:0]    lvl, rise, fall;
  logic                done;
  logic [MAX_BITS-1:0] word;
  logic                word_right;
  rx_state_e           ctrl_state;

  i2s_rx_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i({sd_i, ws_i, sck_i}),
    .q_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  i2s_rx_ctrl #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
    .sck_rise_i(rise[L_SCK]), .ws_lvl_i(lvl[L_WS]),
    .ws_rise_i(rise[L_WS]), .ws_fall_i(fall[L_WS]), .sd_lvl_i(lvl[L_SD]),
    .bit_count_i(bit_count_i), .done_o(done), .word_o(word),
    .word_right_o(word_right), .state_o(ctrl_state)
  );

  i2s_rx_outreg #(.IN_W(MAX_BITS), .OUT_W(OUT_W)) u_out (
    .clk(clk), .rst(rst), .stop_i(stop_i), .done_i(done), .word_i(word),
    .right_i(word_right), .data_o(m_data_o), .right_o(m_right_o),
    .valid_o(m_valid_o), .ready_i(m_ready_i), .overflow_o(overflow_o)
  );
endmodule

// File: rtl/i2s_rx_checker.sv
module i2s_rx_checker
  import i2s_rx_pkg::*;
#(
  parameter int OUT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             stop_i,
  input logic             m_valid_o,
  input logic             m_ready_i,
  input logic [OUT_W-1:0] m_data_o,
  input logic             m_right_o,
  input logic             overflow_o,
  input rx_state_e        ctrl_state
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst || stop_i)
    (m_valid_o && !m_ready_i) |=> (m_valid_o && $stable(m_data_o) && $stable(m_right_o)));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow_o) |-> ($past(m_valid_o) && !$past(m_ready_i)));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (overflow_o && !stop_i) |=> overflow_o);

  assert_stop_clear_R10: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> (!m_valid_o && !overflow_o));

  assert_word_from_read_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(m_valid_o) |-> ($past(ctrl_state, 2) == ST_READ));
endmodule

bind i2s_oversampled_rx i2s_rx_checker #(.OUT_W(OUT_W)) u_checker (
  .clk(clk), .rst(rst), .stop_i(stop_i), .m_valid_o(m_valid_o),
  .m_ready_i(m_ready_i), .m_data_o(m_data_o), .m_right_o(m_right_o),
  .overflow_o(overflow_o), .ctrl_state(ctrl_state)
);

// File: tb/test_i2s_oversampled_rx.sv
`timescale 1ns/1ps
module test_i2s_oversampled_rx;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0, stop_i = 1'b0;
  logic        sck_i = 1'b0, ws_i = 1'b1, sd_i = 1'b0;
  logic [5:0]  bit_count_i = 6'd25;
  logic [23:0] m_data_o;
  logic        m_right_o, m_valid_o, overflow_o;
  logic        m_ready_i = 1'b1;

  int checks = 0, errors = 0;
  logic [24:0] got[$];
  logic [24:0] exp_q[$];

  always #5 clk = ~clk;

  i2s_oversampled_rx i_i2s_oversampled_rx (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
    .sck_i(sck_i), .ws_i(ws_i), .sd_i(sd_i), .bit_count_i(bit_count_i),
    .m_data_o(m_data_o), .m_right_o(m_right_o), .m_valid_o(m_valid_o),
    .m_ready_i(m_ready_i), .overflow_o(overflow_o)
  );

  // behavioural reference model
  logic [2:0]  r_s1 = '0, r_s2 = '0, r_prev = '0;
  int          r_state = 0, r_cnt = 0;
  logic [31:0] r_sh = '0, r_word = '0;
  logic        r_chan = 0, r_pend = 0, r_done = 0, r_wchan = 0;
  logic        r_valid = 0, r_ovf = 0, r_right = 0;
  logic [23:0] r_data = '0;

  always @(posedge clk) begin
    logic sck_r, ws_c, ws_f, pnew;
    if (rst) begin
      r_s1 = '0; r_s2 = '0; r_prev = '0; r_state = 0; r_cnt = 0; r_sh = '0;
      r_chan = 0; r_pend = 0; r_done = 0; r_valid = 0; r_ovf = 0;
      r_data = '0; r_right = 0; r_word = '0; r_wchan = 0;
    end else begin
      if (stop_i) begin r_valid = 0; r_ovf = 0; end
      else if (r_done) begin
        if (!r_valid || m_ready_i) begin
          r_valid = 1; r_data = r_word[23:0]; r_right = r_wchan;
        end else r_ovf = 1;
      end else if (r_valid && m_ready_i) r_valid = 0;
      sck_r = r_s2[0] && !r_prev[0];
      ws_c  = r_s2[1] != r_prev[1];
      ws_f  = !r_s2[1] && r_prev[1];
      if (stop_i) begin
        r_state = 0; r_done = 0; r_pend = 0; r_cnt = 0; r_sh = '0; r_chan = 0;
      end else begin
        r_done = 0;
        pnew = sck_r;
        if (r_state == 0) begin
          if (start_i) r_state = 1;
        end else if (r_state == 1) begin
          if (ws_f) begin r_state = 2; r_cnt = 0; r_sh = '0; r_chan = 0; end
        end else begin
          if (ws_c) begin r_cnt = 0; r_sh = '0; r_chan = r_s2[1]; end
          else if (r_pend && r_cnt < int'(bit_count_i)) begin
            r_sh = {r_sh[30:0], r_s2[2]};
            r_cnt = r_cnt + 1;
            if (r_cnt == int'(bit_count_i)) begin
              r_done = 1; r_word = r_sh; r_wchan = r_chan;
            end
          end
        end
        r_pend = pnew;
      end
      r_prev = r_s2; r_s2 = r_s1; r_s1 = {sd_i, ws_i, sck_i};
    end
  end

  // per-cycle comparison and stream collection (away from the active edge)
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (m_valid_o !== r_valid || overflow_o !== r_ovf ||
          (r_valid && (m_data_o !== r_data || m_right_o !== r_right))) begin
        errors++;
        $display("FAIL R4/R5 model: valid=%0b ovf=%0b data=%h right=%0b expected valid=%0b ovf=%0b data=%h right=%0b",
                 m_valid_o, overflow_o, m_data_o, m_right_o, r_valid, r_ovf, r_data, r_right);
      end
      if (m_valid_o && m_ready_i) got.push_back({m_right_o, m_data_o});
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic slots(input logic ws, input logic [31:0] pat, input int n);
    for (int i = 0; i < n; i++) begin
      sck_i = 1'b0; ws_i = ws; sd_i = pat[31-i];
      tick(HALF);
      sck_i = 1'b1;
      tick(HALF);
    end
  endtask

  task automatic frame(input logic [23:0] l, input logic [23:0] r);
    slots(1'b0, {1'b0, l, 7'b0}, 32);
    slots(1'b1, {1'b0, r, 7'b0}, 32);
  endtask

  task automatic compare_words(input string req);
    tick(20);
    check(got.size() == exp_q.size(), req, "word count", got.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got.size(); i++)
      check(got[i] === exp_q[i], req, "word", {7'b0, got[i]}, {7'b0, exp_q[i]});
    got.delete(); exp_q.delete();
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; tick(1); s = 1'b0;
  endtask

  initial begin
    fork
      begin
        tick(3);
        rst = 1'b0;
        #0;
        check(m_valid_o === 1'b0 && overflow_o === 1'b0, "R1", "reset outputs",
              {30'b0, m_valid_o, overflow_o}, 32'h0);
        // R2: traffic before start yields nothing
        frame(24'h123456, 24'h654321);
        compare_words("R2");
        // R3: arm in the middle of a right slot
        slots(1'b1, 32'hFFFF_FFFF, 10);
        pulse(start_i);
        slots(1'b1, 32'hFFFF_FFFF, 10);
        frame(24'hA5C3F0, 24'h0F1E2D);
        frame(24'h800001, 24'h7FFFFE);
        exp_q.push_back({1'b0, 24'hA5C3F0}); exp_q.push_back({1'b1, 24'h0F1E2D});
        exp_q.push_back({1'b0, 24'h800001}); exp_q.push_back({1'b1, 24'h7FFFFE});
        compare_words("R3 R5 R6");
        // R7: count 16, MSB first, trailing bits ignored
        bit_count_i = 6'd16;
        slots(1'b0, 32'hBEEF_1357, 32);
        slots(1'b1, 32'h4321_FFFF, 32);
        exp_q.push_back({1'b0, 24'h00BEEF}); exp_q.push_back({1'b1, 24'h004321});
        compare_words("R7");
        // R5: count 32 keeps the low 24 bits
        bit_count_i = 6'd32;
        slots(1'b0, 32'hCAFE_BABE, 32);
        slots(1'b1, 32'h0123_4567, 32);
        exp_q.push_back({1'b0, 24'hFEBABE}); exp_q.push_back({1'b1, 24'h234567});
        compare_words("R5");
        // R6: early word-select change drops the partial left word
        bit_count_i = 6'd25;
        slots(1'b0, 32'h7FFF_FFFF, 10);
        slots(1'b1, {1'b0, 24'h13579B, 7'b0}, 32);
        exp_q.push_back({1'b1, 24'h13579B});
        compare_words("R6");
        // R8/R9: stalled consumer
        m_ready_i = 1'b0;
        frame(24'h111111, 24'h222222);
        tick(20);
        check(m_valid_o === 1'b1 && m_data_o === 24'h111111, "R8", "held word",
              {8'b0, m_data_o}, 32'h111111);
        check(overflow_o === 1'b1, "R9", "overflow set", {31'b0, overflow_o}, 32'h1);
        m_ready_i = 1'b1;
        tick(3);
        check(overflow_o === 1'b1, "R9", "overflow sticky", {31'b0, overflow_o}, 32'h1);
        exp_q.push_back({1'b0, 24'h111111});
        compare_words("R9");
        // R10: stop clears, then receiver stays quiet until started
        pulse(stop_i);
        #0;
        check(overflow_o === 1'b0 && m_valid_o === 1'b0, "R10", "stop clear",
              {30'b0, m_valid_o, overflow_o}, 32'h0);
        frame(24'h333333, 24'h444444);
        compare_words("R10");
        pulse(start_i);
        frame(24'h555555, 24'h666666);
        exp_q.push_back({1'b0, 24'h555555}); exp_q.push_back({1'b1, 24'h666666});
        compare_words("R10 R4");
      end
      begin
        tick(150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule